// File: doc/BRIEF.md
# Serial Flash Write-Protection Gatekeeper

This block sits behind the command decoder of a serial NOR flash slave. It decides whether a command that changes data or status may run. Each decoded command arrives as a one-cycle strobe when chip select is released. With the strobe come the opcode, the target address, a flag that says the transfer held a whole number of bytes, and the value a status write would load. The gate checks the command against the write enable latch, the two block-protect bits, the status-lock bit together with the active-low write-protect pin, the deep power-down state and whether an earlier operation is still running. One cycle after the strobe it answers with a single accept pulse or a single reject pulse.

An accepted program, erase or status write marks the device busy. The write enable latch stays set until the array controller reports completion with a done pulse. At that point both busy and the latch clear, so every further modifying command needs a fresh write enable. The protection bits are loaded from a non-volatile value at reset and are exposed as outputs.

Top module: `flash_wp_gate`

## Requirements
- R1: In the cycle after reset is released, `wel` and `busy` are 0 and `{srwd, bp}` equals `nv_status`. The bit order of `nv_status` is {status-lock, BP1, BP0}.
- R2: Opcode encoding on `cmd_op`: 0 none, 1 WREN, 2 WRDI, 3 WRSR, 4 PP, 5 SE, 6 BE, 7 none. A whole-byte WREN that arrives outside power-down and while not busy is accepted and sets `wel`. A WRDI under the same conditions is accepted and clears `wel`.
- R3: WRSR, PP, SE and BE are rejected when `wel` is 0.
- R4: Any command with `cmd_whole` low is rejected.
- R5: BE is accepted only when `bp` is 00.
- R6: With `bp` = 11, PP and SE are rejected for addresses in either sector. Sector 0 is the lower half of the address space and sector 1 the upper half. With `bp` = 00, 01 or 10, PP and SE are not blocked by protection.
- R7: A WRSR is rejected while `wp_n` is 0 and `srwd` is 1, and the status bits then stay unchanged.
- R8: An accepted WRSR loads `cmd_sr`, ordered {status-lock, BP1, BP0}, into `{srwd, bp}` in the same cycle the accept pulse appears.
- R9: While `deep_pd` is 1, every command is rejected.
- R10: An accepted WRSR, PP, SE or BE sets `busy`. While `busy` is set, every command is rejected. An `op_done` pulse while busy clears both `busy` and `wel`. `op_done` while idle has no effect.
- R11: `acc_pulse` and `rej_pulse` rise one cycle after `cmd_valid`, last one cycle and are never high together. Opcodes 0 and 7 raise neither. A rejected command leaves `wel` and the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe: decoded command complete |
| cmd_op | input | 3 | Opcode code (see R2) |
| cmd_addr | input | ADDR_W | Target address for PP/SE |
| cmd_whole | input | 1 | Chip select released after a multiple of eight clocks |
| cmd_sr | input | 3 | New {status-lock, BP1, BP0} for WRSR |
| deep_pd | input | 1 | Device is in deep power-down |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | Completion pulse of the running operation |
| nv_status | input | 3 | Non-volatile {status-lock, BP1, BP0} loaded at reset |
| acc_pulse | output | 1 | Command accepted |
| rej_pulse | output | 1 | Command rejected |
| wel | output | 1 | Write enable latch |
| busy | output | 1 | Accepted operation still running |
| bp | output | 2 | Block-protect bits {BP1, BP0} |
| srwd | output | 1 | Status-lock bit |

## Verification
The assertions check on every cycle that no modifying command is accepted without the latch, in power-down, or as a bulk erase under non-zero protection. They also check that hardware protection freezes the status bits, that completion clears the latch, and that accept and reject never coincide. Only the bench sweep can show that exactly the right commands are accepted across every mix of protection, pin, latch, alignment and address sector, and that a status write loads the requested value. Directed bench scenarios show that a command is rejected while busy and that a done pulse is ignored while idle.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_WREN = 3'd1,
    OP_WRDI = 3'd2,
    OP_WRSR = 3'd3,
    OP_PP   = 3'd4,
    OP_SE   = 3'd5,
    OP_BE   = 3'd6,
    OP_RSVD = 3'd7
  } wp_op_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] bp;
  } wp_stat_t;

  function automatic logic op_modifies(wp_op_e op);
    return (op == OP_WRSR) || (op == OP_PP) || (op == OP_SE) || (op == OP_BE);
  endfunction

  function automatic logic op_known(wp_op_e op);
    return (op != OP_NONE) && (op != OP_RSVD);
  endfunction

endpackage

// File: rtl/wp_region_map.sv
module wp_region_map #(
  parameter int ADDR_W = 16,
  parameter int NSECT  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bp,
  output logic              locked
);
  localparam longint SPAN = (64'd1 << ADDR_W) / NSECT;

  logic [NSECT-1:0] hit;
  logic [NSECT-1:0] ro;

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    localparam longint LO = SPAN * s;
    localparam longint HI = SPAN * (s + 1);
    logic [63:0] a64;
    assign a64    = {{(64-ADDR_W){1'b0}}, addr};
    assign hit[s] = (a64 >= LO) && (a64 < HI);
    // Both protect bits set make every sector read-only.
    assign ro[s]  = (bp == 2'b11);
  end

  assign locked = |(hit & ro);
endmodule

// File: rtl/wp_decide.sv
module wp_decide
  import flash_wp_pkg::*;
(
  input  logic     cmd_valid,
  input  wp_op_e   op,
  input  logic     whole,
  input  logic     deep_pd,
  input  logic     busy,
  input  logic     wel,
  input  logic     wp_n,
  input  wp_stat_t stat,
  input  logic     locked,
  output logic     accept,
  output logic     reject
);
  logic known;
  logic gate_ok;
  logic op_ok;

  always_comb begin
    known   = op_known(op);
    gate_ok = whole && !deep_pd && !busy;
    unique case (op)
      OP_WREN, OP_WRDI: op_ok = 1'b1;
      OP_WRSR:          op_ok = wel && !(!wp_n && stat.lock);
      OP_PP, OP_SE:     op_ok = wel && !locked;
      OP_BE:            op_ok = wel && (stat.bp == 2'b00);
      default:          op_ok = 1'b0;
    endcase
    accept = cmd_valid && known && gate_ok && op_ok;
    reject = cmd_valid && known && !accept;
  end
endmodule

// File: rtl/wp_state.sv
module wp_state
  import flash_wp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     accept,
  input  wp_op_e   op,
  input  wp_stat_t new_stat,
  input  wp_stat_t nv_stat,
  input  logic     op_done,
  output logic     wel,
  output logic     busy,
  output wp_stat_t stat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wel  <= 1'b0;
      busy <= 1'b0;
      stat <= nv_stat;
    end else begin
      if (busy && op_done) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end
      if (accept) begin
        case (op)
          OP_WREN: wel <= 1'b1;
          OP_WRDI: wel <= 1'b0;
          OP_WRSR: begin
            stat <= new_stat;
            busy <= 1'b1;
          end
          OP_PP, OP_SE, OP_BE: busy <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
  import flash_wp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NSECT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_whole,
  input  logic [2:0]        cmd_sr,
  input  logic              deep_pd,
  input  logic              wp_n,
  input  logic              op_done,
  input  logic [2:0]        nv_status,
  output logic              acc_pulse,
  output logic              rej_pulse,
  output logic              wel,
  output logic              busy,
  output logic [1:0]        bp,
  output logic              srwd
);
  wp_op_e   op;
  wp_stat_t stat;
  logic     locked;
  logic     accept;
  logic     reject;

  assign op = wp_op_e'(cmd_op);

  wp_region_map #(.ADDR_W(ADDR_W), .NSECT(NSECT)) u_map (
    .addr   (cmd_addr),
    .bp     (stat.bp),
    .locked (locked)
  );

  wp_decide u_dec (
    .cmd_valid (cmd_valid),
    .op        (op),
    .whole     (cmd_whole),
    .deep_pd   (deep_pd),
    .busy      (busy),
    .wel       (wel),
    .wp_n      (wp_n),
    .stat      (stat),
    .locked    (locked),
    .accept    (accept),
    .reject    (reject)
  );

  wp_state u_st (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .op       (op),
    .new_stat (wp_stat_t'(cmd_sr)),
    .nv_stat  (wp_stat_t'(nv_status)),
    .op_done  (op_done),
    .wel      (wel),
    .busy     (busy),
    .stat     (stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_pulse <= 1'b0;
      rej_pulse <= 1'b0;
    end else begin
      acc_pulse <= accept;
      rej_pulse <= reject;
    end
  end

  assign bp   = stat.bp;
  assign srwd = stat.lock;
endmodule

// File: rtl/flash_wp_gate_chk.sv
module flash_wp_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       deep_pd,
  input logic       wp_n,
  input logic       op_done,
  input logic       acc_pulse,
  input logic       rej_pulse,
  input logic       wel,
  input logic       busy,
  input logic [1:0] bp,
  input logic       srwd
);
  logic is_mod;
  assign is_mod = (cmd_op == 3'd3) || (cmd_op == 3'd4) || (cmd_op == 3'd5) || (cmd_op == 3'd6);

  a_r3_needs_latch: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && is_mod && !wel |=> !acc_pulse);

  a_r5_bulk_clear_bp: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && (cmd_op == 3'd6) && (bp != 2'b00) |=> !acc_pulse);

  a_r7_hw_lock_freeze: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && (cmd_op == 3'd3) && !wp_n && srwd |=> $stable({srwd, bp}));

  a_r9_powerdown_blocks: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && deep_pd |=> !acc_pulse);

  a_r10_done_clears: assert property (@(posedge clk) disable iff (rst)
    busy && op_done |=> !wel && !busy);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(acc_pulse && rej_pulse));

  a_r11_no_cmd_no_pulse: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !acc_pulse && !rej_pulse);
endmodule

bind flash_wp_gate flash_wp_gate_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .deep_pd   (deep_pd),
  .wp_n      (wp_n),
  .op_done   (op_done),
  .acc_pulse (acc_pulse),
  .rej_pulse (rej_pulse),
  .wel       (wel),
  .busy      (busy),
  .bp        (bp),
  .srwd      (srwd)
);

// File: tb/sim_flash_wp_gate.sv
module sim_flash_wp_gate;
  localparam int PERIOD = 10;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic cmd_whole = 1'b1;
  logic [2:0] cmd_sr = 3'd0;
  logic deep_pd = 1'b0;
  logic wp_n = 1'b1;
  logic op_done = 1'b0;
  logic [2:0] nv_status = 3'd0;
  logic acc_pulse, rej_pulse, wel, busy, srwd;
  logic [1:0] bp;

  int checks = 0;
  int errors = 0;
  logic got_acc, got_rej;

  always #(PERIOD/2) clk = ~clk;

  flash_wp_gate #(.ADDR_W(AW), .NSECT(2)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_whole(cmd_whole), .cmd_sr(cmd_sr),
    .deep_pd(deep_pd), .wp_n(wp_n), .op_done(op_done), .nv_status(nv_status),
    .acc_pulse(acc_pulse), .rej_pulse(rej_pulse), .wel(wel), .busy(busy),
    .bp(bp), .srwd(srwd)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] nv);
    @(negedge clk);
    rst = 1'b1; nv_status = nv;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Drives a one-cycle command; samples the pulses one cycle later.
  task automatic send(input logic [2:0] op, input logic [AW-1:0] a,
                      input logic whole, input logic [2:0] sr);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_whole = whole; cmd_sr = sr;
    @(negedge clk);
    cmd_valid = 1'b0;
    got_acc = acc_pulse; got_rej = rej_pulse;
  endtask

  task automatic done_pulse();
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    $display("FAIL watchdog actual 0 expected 1");
    errors++;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int mods[4];
    mods = '{3, 4, 5, 6};
    // Near-exhaustive sweep over protection, pin, power-down, alignment, latch, opcode and sector.
    for (int nv = 0; nv < 8; nv++) begin
      for (int wp = 0; wp < 2; wp++) begin
        for (int dp = 0; dp < 2; dp++) begin
          for (int wh = 0; wh < 2; wh++) begin
            for (int we = 0; we < 2; we++) begin
              for (int oi = 0; oi < 4; oi++) begin
                for (int sec = 0; sec < 2; sec++) begin
                  logic [2:0] op, nsr, exp_sr;
                  logic [1:0] b;
                  logic lk, exp_acc;
                  logic [AW-1:0] a;
                  op = 3'(mods[oi]);
                  b = 2'(nv & 3); lk = nv[2];
                  nsr = ~3'(nv);
                  a = sec ? 16'hC001 : 16'h1234;
                  wp_n = 1'(wp); deep_pd = 1'b0;
                  do_reset(3'(nv));
                  chk(wel == 0 && busy == 0 && {srwd, bp} == 3'(nv), "R1 reset",
                      {wel, busy, srwd, bp}, nv);
                  if (we != 0) begin
                    send(3'd1, '0, 1'b1, 3'd0);
                    chk(got_acc && wel, "R2 wren", {got_acc, wel}, 3);
                  end
                  deep_pd = 1'(dp);
                  exp_acc = (dp == 0) && (wh == 1) && (we == 1);
                  case (op)
                    3'd3: exp_acc = exp_acc && !(wp == 0 && lk);
                    3'd6: exp_acc = exp_acc && (b == 2'b00);
                    default: exp_acc = exp_acc && (b != 2'b11);
                  endcase
                  send(op, a, 1'(wh), nsr);
                  chk(got_acc == exp_acc && got_rej == !exp_acc,
                      "R3 R4 R5 R6 R7 R9 verdict", {got_acc, got_rej}, {exp_acc, !exp_acc});
                  exp_sr = (exp_acc && op == 3'd3) ? nsr : 3'(nv);
                  chk({srwd, bp} == exp_sr, "R8 R7 R11 status", {srwd, bp}, exp_sr);
                  chk(wel == 1'(we) && busy == exp_acc, "R10 R11 latch/busy",
                      {wel, busy}, {1'(we), exp_acc});
                  deep_pd = 1'b0;
                  if (exp_acc) begin
                    done_pulse();
                    chk(wel == 0 && busy == 0, "R10 done clears", {wel, busy}, 0);
                  end
                end
              end
            end
          end
        end
      end
    end

    // Directed: WRDI, busy rejection, idle done, misaligned WREN, power-down WREN, unused opcodes.
    wp_n = 1'b1; deep_pd = 1'b0;
    do_reset(3'd0);
    send(3'd1, '0, 1'b1, 3'd0);
    send(3'd2, '0, 1'b1, 3'd0);
    chk(got_acc && !wel, "R2 wrdi clears", {got_acc, wel}, 2);
    send(3'd1, '0, 1'b0, 3'd0);
    chk(got_rej && !wel, "R4 misaligned wren", {got_rej, wel}, 2);
    deep_pd = 1'b1;
    send(3'd1, '0, 1'b1, 3'd0);
    chk(got_rej && !wel, "R9 wren in power-down", {got_rej, wel}, 2);
    deep_pd = 1'b0;
    send(3'd1, '0, 1'b1, 3'd0);
    done_pulse();
    chk(wel == 1 && busy == 0, "R10 idle done ignored", {wel, busy}, 2);
    send(3'd4, 16'h0010, 1'b1, 3'd0);
    chk(got_acc && busy, "R10 pp starts busy", {got_acc, busy}, 3);
    send(3'd1, '0, 1'b1, 3'd0);
    chk(got_rej && !got_acc, "R10 busy rejects", {got_acc, got_rej}, 1);
    send(3'd0, '0, 1'b1, 3'd0);
    chk(!got_acc && !got_rej, "R11 opcode 0 silent", {got_acc, got_rej}, 0);
    send(3'd7, '0, 1'b1, 3'd0);
    chk(!got_acc && !got_rej, "R11 opcode 7 silent", {got_acc, got_rej}, 0);
    @(negedge clk);
    chk(!acc_pulse && !rej_pulse, "R11 single-cycle pulse", {acc_pulse, rej_pulse}, 0);
    done_pulse();
    chk(!wel && !busy, "R10 done after pp", {wel, busy}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule